// File: doc/BRIEF.md
# Trigger-Configurable Interrupt Aggregator

This block collects a group of interrupt sources and condenses them onto two processor request lines: a fast request and a normal request. Software sets, for each source on its own, whether it is enabled, whether it fires on a level or on an edge, which polarity counts as active, and which of the two request lines it feeds. Every input passes through a two-flop synchronizer before any detection.

Edge events are latched and held until software clears them by writing a one to the matching bit of the raw status address. Level sources simply follow the synchronized input. The raw status view shows every source whether or not it is enabled. The masked view shows only enabled ones. A small register port exposes all of this. Reads are combinational and writes take effect at the clock edge.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every configuration register reads zero: all sources disabled, level type, active-high, steered to the normal request. Both request outputs are low and both status views read zero.
- R2: With type bit 0 and polarity bit 0, a source's raw status bit is 1 while its input is high and drops to 0 when the input goes low.
- R3: With type bit 0 and polarity bit 1, a source's raw status bit is 1 while its input is low.
- R4: With type bit 1 and polarity bit 0, a 0-to-1 transition latches the raw bit to 1. The bit stays 1 after the input returns low.
- R5: With type bit 1 and polarity bit 1, a 1-to-0 transition latches the raw bit to 1, and a 0-to-1 transition does not.
- R6: Writing the raw status address (4) clears every latched edge source whose data bit is 1. Data bits of 0 leave their latched sources set, and level sources are not affected.
- R7: The masked status (address 5) equals raw status ANDed with the enable register, and raw status does not depend on the enables.
- R8: A steering bit of 1 routes a source to fiq_o and 0 routes it to irq_o. Each output is the OR of the masked sources routed to it.
- R9: A write that changes a source's polarity or type bit clears that source's latched edge. Sources whose bits do not change keep their latched edges.
- R10: An input change is captured by two flops. A level source's raw bit changes after the second rising clock edge, and not after the first.
- R11: Register map: 0 enable, 1 polarity, 2 type, 3 steering, all read/write with readback. 4 is raw status, 5 is masked status. Writes to 5 are ignored, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | N_SRC | Asynchronous interrupt source lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | N_SRC | Register write data |
| reg_rdata_o | output | N_SRC | Register read data (combinational) |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |

## Verification
The bench targets the latch semantics first. An edge source must hold after its input falls back, and a design that passed edges through as levels would lose the bit. Clear writes carrying zero bits, or aimed at level sources, must change nothing, and a design that cleared the whole register would drop unrelated events. Reprogramming is checked per bit: a rewrite with an unchanged polarity must keep the latch, and a design that cleared on every write would fail that case. Synchronizer depth is checked one edge at a time, and routing is checked by swapping the steering bit while the request is active.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_EN     = 3'd0,
    ADDR_POL    = 3'd1,
    ADDR_TYPE   = 3'd2,
    ADDR_STEER  = 3'd3,
    ADDR_RAW    = 3'd4,
    ADDR_MASKED = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/irq_agg_cfg.sv
module irq_agg_cfg
  import irq_agg_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  en_o,
  output logic [N_SRC-1:0]  pol_o,
  output logic [N_SRC-1:0]  type_o,
  output logic [N_SRC-1:0]  steer_o,
  output logic [N_SRC-1:0]  clr_o,
  output logic [N_SRC-1:0]  chg_o
);
  logic [N_SRC-1:0] en_q, pol_q, type_q, steer_q;
  logic wr_en, wr_pol, wr_type, wr_steer, wr_raw;

  assign wr_en    = we_i && (addr_i == ADDR_EN);
  assign wr_pol   = we_i && (addr_i == ADDR_POL);
  assign wr_type  = we_i && (addr_i == ADDR_TYPE);
  assign wr_steer = we_i && (addr_i == ADDR_STEER);
  assign wr_raw   = we_i && (addr_i == ADDR_RAW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      pol_q   <= '0;
      type_q  <= '0;
      steer_q <= '0;
    end else begin
      if (wr_en)    en_q    <= wdata_i;
      if (wr_pol)   pol_q   <= wdata_i;
      if (wr_type)  type_q  <= wdata_i;
      if (wr_steer) steer_q <= wdata_i;
    end
  end

  // per-bit change strobes for pending-edge flush
  always_comb begin
    chg_o = '0;
    if (wr_pol)  chg_o = chg_o | (wdata_i ^ pol_q);
    if (wr_type) chg_o = chg_o | (wdata_i ^ type_q);
  end

  assign clr_o   = wr_raw ? wdata_i : '0;
  assign en_o    = en_q;
  assign pol_o   = pol_q;
  assign type_o  = type_q;
  assign steer_o = steer_q;

  assert_chg_means_cfg_moved_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_o != '0) |=> ((pol_q != $past(pol_q)) || (type_q != $past(type_q))));
endmodule

// File: rtl/irq_agg_detect.sv
module irq_agg_detect #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] sync_i,
  input  logic [N_SRC-1:0] pol_i,
  input  logic [N_SRC-1:0] type_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic [N_SRC-1:0] chg_i,
  output logic [N_SRC-1:0] raw_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic prev_q, pend_q, evt;

    // pol=0 selects rising, pol=1 selects falling
    assign evt = type_i[i] && (pol_i[i] ? (prev_q && !sync_i[i])
                                        : (!prev_q && sync_i[i]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        prev_q <= sync_i[i];
        if (chg_i[i]) pend_q <= 1'b0;
        else          pend_q <= (pend_q && !clr_i[i]) || evt;
      end
    end

    assign raw_o[i] = type_i[i] ? pend_q : (sync_i[i] ^ pol_i[i]);

    assert_edge_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (type_i[i] && pend_q && !clr_i[i] && !chg_i[i]) |=> pend_q);

    assert_w1c_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (type_i[i] && clr_i[i] && !evt && !chg_i[i]) |=> !pend_q);

    assert_cfg_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chg_i[i] |=> !pend_q);
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [N_SRC-1:0]  reg_wdata_i,
  output logic [N_SRC-1:0]  reg_rdata_o,
  output logic              fiq_o,
  output logic              irq_o
);
  logic [N_SRC-1:0] sync, en, pol, typ, steer, clr, chg, raw, masked;

  irq_agg_sync #(.W(N_SRC)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (src_i),
    .sync_o  (sync)
  );

  irq_agg_cfg #(.N_SRC(N_SRC)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .en_o    (en),
    .pol_o   (pol),
    .type_o  (typ),
    .steer_o (steer),
    .clr_o   (clr),
    .chg_o   (chg)
  );

  irq_agg_detect #(.N_SRC(N_SRC)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync),
    .pol_i  (pol),
    .type_i (typ),
    .clr_i  (clr),
    .chg_i  (chg),
    .raw_o  (raw)
  );

  assign masked = raw & en;
  assign fiq_o  = |(masked & steer);
  assign irq_o  = |(masked & ~steer);

  always_comb begin
    unique case (reg_addr_i)
      ADDR_EN:     reg_rdata_o = en;
      ADDR_POL:    reg_rdata_o = pol;
      ADDR_TYPE:   reg_rdata_o = typ;
      ADDR_STEER:  reg_rdata_o = steer;
      ADDR_RAW:    reg_rdata_o = raw;
      ADDR_MASKED: reg_rdata_o = masked;
      default:     reg_rdata_o = '0;
    endcase
  end

  assert_quiet_when_disabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> (!fiq_o && !irq_o));

  assert_irq_route_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en & ~steer) == '0) |-> !irq_o);

  assert_fiq_route_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en & steer) == '0) |-> !fiq_o);
endmodule

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] src = '0;
  logic         we = 1'b0;
  logic [2:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         fiq, irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_aggregator #(.N_SRC(N)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .src_i       (src),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .fiq_o       (fiq),
    .irq_o       (irq)
  );

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic drive(input int b, input logic v);
    @(negedge clk);
    src[b] = v;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], d);
      check("R1 reset reg", d, '0);
    end
    check("R1 fiq after reset", {7'd0, fiq}, '0);
    check("R1 irq after reset", {7'd0, irq}, '0);
    rd(3'd6, d);
    check("R11 unmapped read", d, '0);
  endtask

  task automatic t_level_high();
    logic [N-1:0] d;
    drive(0, 1'b1);
    @(posedge clk);
    rd(3'd4, d);
    check("R10 one edge not visible", d & 8'h01, 8'h00);
    @(posedge clk);
    rd(3'd4, d);
    check("R10 two edges visible", d & 8'h01, 8'h01);
    check("R2 level high set", d & 8'h01, 8'h01);
    drive(0, 1'b0);
    settle();
    rd(3'd4, d);
    check("R2 level high follows low", d & 8'h01, 8'h00);
  endtask

  task automatic t_level_low();
    logic [N-1:0] d;
    wr(3'd1, 8'h02);
    settle();
    rd(3'd4, d);
    check("R3 level low active", d & 8'h02, 8'h02);
    drive(1, 1'b1);
    settle();
    rd(3'd4, d);
    check("R3 level low inactive", d & 8'h02, 8'h00);
    drive(1, 1'b0);
    wr(3'd1, 8'h00);
    settle();
  endtask

  task automatic t_rise();
    logic [N-1:0] d;
    wr(3'd2, 8'h04);
    drive(2, 1'b1);
    settle();
    drive(2, 1'b0);
    settle();
    rd(3'd4, d);
    check("R4 rising latched after drop", d & 8'h04, 8'h04);
    wr(3'd4, 8'h00);
    rd(3'd4, d);
    check("R6 zero bits keep latch", d & 8'h04, 8'h04);
    drive(0, 1'b1);
    settle();
    wr(3'd4, 8'h01);
    rd(3'd4, d);
    check("R6 level unaffected by clear", d & 8'h01, 8'h01);
    wr(3'd4, 8'h04);
    rd(3'd4, d);
    check("R6 w1c clears edge", d & 8'h04, 8'h00);
    drive(0, 1'b0);
    wr(3'd2, 8'h00);
    settle();
  endtask

  task automatic t_fall();
    logic [N-1:0] d;
    wr(3'd2, 8'h08);
    wr(3'd1, 8'h08);
    drive(3, 1'b1);
    settle();
    rd(3'd4, d);
    check("R5 rising ignored", d & 8'h08, 8'h00);
    drive(3, 1'b0);
    settle();
    rd(3'd4, d);
    check("R5 falling latched", d & 8'h08, 8'h08);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00);
    settle();
  endtask

  task automatic t_mask_steer();
    logic [N-1:0] d;
    drive(4, 1'b1);
    drive(5, 1'b1);
    settle();
    rd(3'd4, d);
    check("R7 raw independent of enable", d, 8'h30);
    rd(3'd5, d);
    check("R7 masked zero when disabled", d, 8'h00);
    check("R7 no request when disabled", {6'd0, fiq, irq}, 8'h00);
    wr(3'd0, 8'h10);
    rd(3'd5, d);
    check("R7 masked = raw & en", d, 8'h10);
    check("R8 routed to irq", {6'd0, fiq, irq}, 8'h01);
    wr(3'd3, 8'h10);
    rd(3'd3, d);
    check("R11 steer readback", d, 8'h10);
    check("R8 routed to fiq", {6'd0, fiq, irq}, 8'h02);
    wr(3'd0, 8'h30);
    rd(3'd5, d);
    check("R7 masked two sources", d, 8'h30);
    check("R8 both requests", {6'd0, fiq, irq}, 8'h03);
    wr(3'd5, 8'hFF);
    rd(3'd0, d);
    check("R11 masked write ignored en", d, 8'h30);
    rd(3'd5, d);
    check("R11 masked write ignored", d, 8'h30);
    drive(4, 1'b0);
    settle();
    check("R8 fiq group empties", {6'd0, fiq, irq}, 8'h01);
    drive(5, 1'b0);
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h00);
    settle();
  endtask

  task automatic t_cfg_clear();
    logic [N-1:0] d;
    wr(3'd2, 8'hC0);
    drive(6, 1'b1);
    drive(7, 1'b1);
    settle();
    rd(3'd4, d);
    check("R4 two rising latched", d & 8'hC0, 8'hC0);
    wr(3'd1, 8'h40);
    rd(3'd4, d);
    check("R9 changed source cleared", d & 8'hC0, 8'h80);
    wr(3'd1, 8'h40);
    rd(3'd4, d);
    check("R9 unchanged rewrite keeps", d & 8'hC0, 8'h80);
    rd(3'd1, d);
    check("R11 pol readback", d, 8'h40);
    rd(3'd2, d);
    check("R11 type readback", d, 8'hC0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    t_reset();
    t_level_high();
    t_level_low();
    t_rise();
    t_fall();
    t_mask_steer();
    t_cfg_clear();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule